// File: doc/BRIEF.md
# Floating-Point Carry-Save Multiplier

This block multiplies two 16-bit floating-point operands. Each operand has one sign bit, a 5-bit biased exponent (bias 15) and a 10-bit stored fraction with an implied leading one. The result uses the same format and comes with three status flags. The sign of the result is the exclusive OR of the operand signs. The exponents are added and the bias is taken out once. The two 11-bit significands are multiplied in a combinational array. An AND stage forms every partial-product bit at its weighted position. A parallel tree of 3:2 carry-save rows then reduces those rows to a sum vector and a carry vector, and one carry-propagate adder joins the two.

A normalizer looks at the top bit of the 22-bit raw product. When that bit is set, it moves the fraction one place and adds one to the exponent. The fraction is truncated, with no rounding. Results whose exponent is too large saturate and raise an overflow flag. Results whose exponent is too small are flushed to zero. The result, the flags and a valid strobe are registered, so each accepted operand pair yields one result one clock later.

Top module: `fmul_cs_top`

## Requirements
- R1: The result sign bit (bit 15) and `flagSign` both equal opA[15] XOR opB[15], including for zero, flushed and saturated results.
- R2: The significands {1, fraction} are multiplied exactly, and the stored result fraction is the truncated product with the leading one removed.
- R3: When the raw 22-bit product has bit 21 set, the fraction is taken from bits 20..11 and the exponent gains one. Otherwise the fraction is bits 19..10.
- R4: The result exponent field (bits 14..10) equals expA + expB − 15 + shift, where shift is the R3 adjustment, whenever that value lies in 1..30.
- R5: When expA + expB − 15 + shift is 31 or more, `flagOverflow` is 1 and the result is the sign followed by 15'h7BFF, the largest finite magnitude. A value of exactly 30 is not an overflow.
- R6: When expA + expB − 15 + shift is below 1, the result magnitude (bits 14..0) is 0 and `flagZero` is 1. A value of exactly 1 is kept.
- R7: An operand whose bits 14..0 are all zero forces a zero magnitude with `flagZero` = 1 and `flagOverflow` = 0, whatever the other operand is.
- R8: A pair presented with `inValid` high at a rising edge appears on `result` and the flags, with `outValid` high, after that edge. `outValid` is low after any edge at which `inValid` was low.
- R9: An active-low `rstN` clears `outValid`, `result` and all flags at once, without waiting for a clock edge.
- R10: While `inValid` is low, `result` and the flags keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair on opA/opB is to be multiplied |
| opA | input | 16 | First operand: sign, 5-bit exponent, 10-bit fraction |
| opB | input | 16 | Second operand, same format |
| outValid | output | 1 | Result registered from the previous edge's pair |
| result | output | 16 | Product in the operand format |
| flagSign | output | 1 | Sign of the result |
| flagZero | output | 1 | Result magnitude is zero |
| flagOverflow | output | 1 | Exponent exceeded the format and the result saturated |

## Verification
Every result and flag is due exactly one rising edge after the pair is accepted. The only register in the path is the output stage, and `outValid` follows `inValid` through one flop. The bench drives operands on a falling edge and reads the outputs on the next falling edge. Its hold checks read the outputs again one full cycle later, with `inValid` low and different operands present. The reset check reads the outputs in the middle of a cycle, right after `rstN` falls, before any edge could clear them.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  typedef struct packed {
    logic load;
  } fmulStrobe_t;

  function automatic int csaNext(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  function automatic int csaCountAt(input int n, input int lvl);
    int c;
    c = n;
    for (int i = 0; i < lvl; i++) c = csaNext(c);
    return c;
  endfunction

  function automatic int csaLevels(input int n);
    int c;
    int l;
    c = n;
    l = 0;
    while (c > 2) begin
      c = csaNext(c);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/fmul_ppgen.sv
module fmul_ppgen #(
  parameter int SIG_W = 11
) (
  input  logic [SIG_W-1:0]   sigX,
  input  logic [SIG_W-1:0]   sigY,
  output logic [2*SIG_W-1:0] ppRows [SIG_W]
);
  localparam int PROD_W = 2 * SIG_W;

  for (genvar r = 0; r < SIG_W; r++) begin : g_row
    logic [SIG_W-1:0] andBits;
    assign andBits = sigX & {SIG_W{sigY[r]}};
    assign ppRows[r] = PROD_W'({{SIG_W{1'b0}}, andBits} << r);
  end
endmodule

// File: rtl/fmul_csa_tree.sv
module fmul_csa_tree import fmul_pkg::*; #(
  parameter int ROWS  = 11,
  parameter int WIDTH = 22
) (
  input  logic [WIDTH-1:0] inRows [ROWS],
  output logic [WIDTH-1:0] sumVec,
  output logic [WIDTH-1:0] carryVec
);
  localparam int LEVELS = csaLevels(ROWS);

  logic [WIDTH-1:0] lvl [LEVELS+1][ROWS];

  for (genvar i = 0; i < ROWS; i++) begin : g_in
    assign lvl[0][i] = inRows[i];
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int CNT = csaCountAt(ROWS, l);
    localparam int GRP = CNT / 3;
    localparam int REM = CNT % 3;
    localparam int USED = 2 * GRP + REM;

    for (genvar g = 0; g < GRP; g++) begin : g_fa
      logic [WIDTH-1:0] xA, xB, xC;
      assign xA = lvl[l][3*g];
      assign xB = lvl[l][3*g+1];
      assign xC = lvl[l][3*g+2];
      assign lvl[l+1][2*g]   = xA ^ xB ^ xC;
      assign lvl[l+1][2*g+1] = ((xA & xB) | (xA & xC) | (xB & xC)) << 1;
    end

    for (genvar r = 0; r < REM; r++) begin : g_pass
      assign lvl[l+1][2*GRP+r] = lvl[l][3*GRP+r];
    end

    for (genvar u = USED; u < ROWS; u++) begin : g_idle
      assign lvl[l+1][u] = '0;
    end
  end

  assign sumVec   = lvl[LEVELS][0];
  assign carryVec = lvl[LEVELS][1];
endmodule

// File: rtl/fmul_norm.sv
module fmul_norm #(
  parameter int FRAC_W = 10
) (
  input  logic [2*FRAC_W+1:0] prodRaw,
  output logic [FRAC_W-1:0]   fracOut,
  output logic                normShift
);
  localparam int PROD_W = 2 * FRAC_W + 2;

  assign normShift = prodRaw[PROD_W-1];
  assign fracOut   = normShift ? prodRaw[PROD_W-2 -: FRAC_W]
                               : prodRaw[PROD_W-3 -: FRAC_W];
endmodule

// File: rtl/fmul_ctrl.sv
module fmul_ctrl import fmul_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output fmulStrobe_t strobe,
  output logic        outValid
);
  assign strobe.load = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/fmul_datapath.sv
module fmul_datapath import fmul_pkg::*; #(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  fmulStrobe_t               strobe,
  input  logic [EXP_W+FRAC_W:0]     opA,
  input  logic [EXP_W+FRAC_W:0]     opB,
  output logic [EXP_W+FRAC_W:0]     result,
  output logic                      flagSign,
  output logic                      flagZero,
  output logic                      flagOverflow
);
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 2;
  localparam int EC_W    = EXP_W + 2;

  logic             signRes;
  logic [EXP_W-1:0] expA, expB;
  logic [SIG_W-1:0] sigA, sigB;
  logic             zeroIn;

  assign signRes = opA[WORD_W-1] ^ opB[WORD_W-1];
  assign expA    = opA[WORD_W-2 -: EXP_W];
  assign expB    = opB[WORD_W-2 -: EXP_W];
  assign sigA    = {1'b1, opA[FRAC_W-1:0]};
  assign sigB    = {1'b1, opB[FRAC_W-1:0]};
  assign zeroIn  = (opA[WORD_W-2:0] == '0) || (opB[WORD_W-2:0] == '0);

  logic [PROD_W-1:0] ppRows [SIG_W];
  logic [PROD_W-1:0] sumVec, carryVec, prodRaw;
  logic [FRAC_W-1:0] fracN;
  logic              normShift;

  fmul_ppgen #(.SIG_W(SIG_W)) u_ppgen (
    .sigX(sigA), .sigY(sigB), .ppRows(ppRows)
  );

  fmul_csa_tree #(.ROWS(SIG_W), .WIDTH(PROD_W)) u_tree (
    .inRows(ppRows), .sumVec(sumVec), .carryVec(carryVec)
  );

  assign prodRaw = sumVec + carryVec;

  fmul_norm #(.FRAC_W(FRAC_W)) u_norm (
    .prodRaw(prodRaw), .fracOut(fracN), .normShift(normShift)
  );

  logic [EC_W-1:0]   expSum;
  logic [EC_W-1:0]   expField;
  logic              underflow, overflow;
  logic [WORD_W-1:0] resNext;
  logic              zeroNext, ovfNext;

  assign expSum    = EC_W'(expA) + EC_W'(expB) + EC_W'(normShift);
  assign expField  = expSum - EC_W'(BIAS);
  assign underflow = expSum < EC_W'(BIAS + 1);
  assign overflow  = expSum > EC_W'(EXP_MAX + BIAS);

  always_comb begin
    zeroNext = 1'b0;
    ovfNext  = 1'b0;
    if (zeroIn || underflow) begin
      resNext  = {signRes, {(WORD_W-1){1'b0}}};
      zeroNext = 1'b1;
    end else if (overflow) begin
      resNext  = {signRes, EXP_W'(EXP_MAX), {FRAC_W{1'b1}}};
      ovfNext  = 1'b1;
    end else begin
      resNext  = {signRes, expField[EXP_W-1:0], fracN};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result       <= '0;
      flagSign     <= 1'b0;
      flagZero     <= 1'b0;
      flagOverflow <= 1'b0;
    end else if (strobe.load) begin
      result       <= resNext;
      flagSign     <= signRes;
      flagZero     <= zeroNext;
      flagOverflow <= ovfNext;
    end
  end
endmodule

// File: rtl/fmul_cs_top.sv
module fmul_cs_top import fmul_pkg::*; #(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  output logic                  outValid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  flagSign,
  output logic                  flagZero,
  output logic                  flagOverflow
);
  fmulStrobe_t strobe;

  fmul_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  fmul_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .result(result), .flagSign(flagSign), .flagZero(flagZero),
    .flagOverflow(flagOverflow)
  );
endmodule

// File: rtl/fmul_cs_checker.sv
module fmul_cs_checker #(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic [EXP_W+FRAC_W:0] opA,
  input logic [EXP_W+FRAC_W:0] opB,
  input logic                  outValid,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  flagSign,
  input logic                  flagZero,
  input logic                  flagOverflow
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r1_sign_xor: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (flagSign == ($past(opA[WORD_W-1]) ^ $past(opB[WORD_W-1])))
                && (result[WORD_W-1] == flagSign));

  a_r7_zero_operand: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (opA[WORD_W-2:0] == '0 || opB[WORD_W-2:0] == '0)
    |=> flagZero && !flagOverflow && result[WORD_W-2:0] == '0);

  a_r5_saturate_pattern: assert property (@(posedge clk) disable iff (!rstN)
    flagOverflow |-> result[WORD_W-2:0] == {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}});

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(flagZero && flagOverflow));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result) && $stable(flagZero) && $stable(flagOverflow));
endmodule

bind fmul_cs_top fmul_cs_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
  .outValid(outValid), .result(result), .flagSign(flagSign),
  .flagZero(flagZero), .flagOverflow(flagOverflow)
);

// File: tb/tb_fmul_cs_top.sv
module tb_fmul_cs_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  localparam int NRAND = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        outValid;
  logic [15:0] result;
  logic        flagSign, flagZero, flagOverflow;

  int total = 0;
  int bad = 0;

  fmul_cs_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .flagSign(flagSign),
    .flagZero(flagZero), .flagOverflow(flagOverflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {opA, opB, expected result, expected zero, expected overflow}
  localparam logic [49:0] VEC [NVEC] = '{
    {16'h3C00, 16'h3C00, 16'h3C00, 1'b0, 1'b0},  // R2 1*1
    {16'h4000, 16'h4200, 16'h4600, 1'b0, 1'b0},  // R4 2*3
    {16'h3E00, 16'h3E00, 16'h4080, 1'b0, 1'b0},  // R3 1.5*1.5
    {16'hC000, 16'h4200, 16'hC600, 1'b0, 1'b0},  // R1 -2*3
    {16'hC000, 16'hC200, 16'h4600, 1'b0, 1'b0},  // R1 -2*-3
    {16'h3FFF, 16'h3FFF, 16'h43FE, 1'b0, 1'b0},  // R2 truncation
    {16'h7800, 16'h3C00, 16'h7800, 1'b0, 1'b0},  // R5 exponent 30 kept
    {16'h7800, 16'h4000, 16'h7BFF, 1'b0, 1'b1},  // R5 exponent 31
    {16'hF800, 16'h7800, 16'hFBFF, 1'b0, 1'b1},  // R5 negative saturate
    {16'h0400, 16'h3C00, 16'h0400, 1'b0, 1'b0},  // R6 exponent 1 kept
    {16'h0400, 16'h0400, 16'h0000, 1'b1, 1'b0},  // R6 flush
    {16'h0000, 16'h4200, 16'h0000, 1'b1, 1'b0},  // R7 zero operand
    {16'h8000, 16'h7BFF, 16'h8000, 1'b1, 1'b0}   // R7 signed zero
  };

  function automatic logic [17:0] model(input logic [15:0] a, input logic [15:0] b);
    logic sgn;
    int prod, e, frac;
    sgn = a[15] ^ b[15];
    if (a[14:0] == 0 || b[14:0] == 0) return {sgn, 15'd0, 1'b1, 1'b0};
    prod = (1024 + int'(a[9:0])) * (1024 + int'(b[9:0]));
    e = int'(a[14:10]) + int'(b[14:10]) - 15;
    if (prod >= 2097152) begin
      e = e + 1;
      frac = (prod >> 11) & 1023;
    end else begin
      frac = (prod >> 10) & 1023;
    end
    if (e < 1) return {sgn, 15'd0, 1'b1, 1'b0};
    if (e > 30) return {sgn, 15'h7BFF, 1'b0, 1'b1};
    return {sgn, 5'(e), 10'(frac), 1'b0, 1'b0};
  endfunction

  task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] a, input logic [15:0] b,
                     input logic [15:0] eRes, input logic eZero, input logic eOvf,
                     input string req);
    @(negedge clk);
    opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    check(req, {outValid, flagSign, flagZero, flagOverflow, result[14:0]},
          {1'b1, eRes[15], eZero, eOvf, eRes[14:0]});
    check("R1 sign bit", {18'd0, result[15]}, {18'd0, eRes[15]});
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [17:0] m;
    logic [15:0] lastRes;
    logic [15:0] ra, rb;
    // R9 reset state
    #(CLK_PERIOD * 2 + 2);
    check("R9 reset state", {outValid, flagSign, flagZero, flagOverflow, result[14:0]}, '0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      run(VEC[i][49:34], VEC[i][33:18], VEC[i][17:2], VEC[i][1], VEC[i][0], "R2 R3 R4 R5 R6 R7 vector");
      m = model(VEC[i][49:34], VEC[i][33:18]);
      check("R8 model agrees with table", {1'b0, m}, {1'b0, VEC[i][17:0]});
    end

    for (int i = 0; i < NRAND; i++) begin
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (ra[14:10] == 5'd31) ra[14:10] = 5'd30;
      if (rb[14:10] == 5'd31) rb[14:10] = 5'd30;
      if (ra[14:10] == 5'd0) ra[9:0] = '0;
      if (rb[14:10] == 5'd0) rb[9:0] = '0;
      m = model(ra, rb);
      run(ra, rb, m[17:2], m[1], m[0], "R4 random product");
    end

    // R10 hold with inValid low, R8 outValid drops
    run(16'h4000, 16'h4200, 16'h4600, 1'b0, 1'b0, "R8 before hold");
    lastRes = result;
    @(negedge clk);
    opA = 16'h7800; opB = 16'h7800; inValid = 1'b0;
    @(negedge clk);
    check("R10 hold result", {3'd0, result}, {3'd0, lastRes});
    check("R10 hold flags", {16'd0, flagZero, flagOverflow, flagSign}, 19'd0);
    check("R8 outValid low", {18'd0, outValid}, 19'd0);
    @(negedge clk);
    check("R10 hold second cycle", {3'd0, result}, {3'd0, lastRes});

    // R9 asynchronous reset mid-cycle
    run(16'hF800, 16'h7800, 16'hFBFF, 1'b0, 1'b1, "R5 before reset");
    #(CLK_PERIOD / 4);
    rstN = 1'b0;
    #1;
    check("R9 async clear", {outValid, flagSign, flagZero, flagOverflow, result[14:0]}, '0);
    check("R9 async clear sign bit", {18'd0, result[15]}, 19'd0);
    @(negedge clk);
    rstN = 1'b1;
    run(16'h3E00, 16'h3E00, 16'h4080, 1'b0, 1'b0, "R3 after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule